// File: doc/BRIEF.md
# Set-per-Row DRAM Cache Controller

This block controls a last-level cache whose storage is a stacked DRAM. Each cache set is one 2 KB DRAM row of thirty-two 64-byte slots. Slots 0 and 1 of the row hold the tag entries for the set, and slots 2 through 31 hold the data of thirty ways. A lookup therefore opens one row only. The controller precharges the bank, activates the set's row, and reads both tag slots with a single burst of eight beats. It then compares the requested tag against all thirty ways in one cycle and goes to the matching data slot in the same open row.

The upstream cache presents a block address, a read/write flag and a 512-bit write block. A ready/valid handshake allows one request in flight at a time. A read hit returns the block. A write hit stores the block and then writes the tag slots back with that way marked dirty. A miss reports a victim way: the lowest-numbered invalid way if there is one, and otherwise a round-robin pointer. Filling from main memory is handled elsewhere.

Top module: `rowtag_cache_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, dram_cmd is idle (0) and dram_wvalid is 0.
- R2: For each accepted request the controller issues precharge (cmd 1) to the set row, which is block-address bits [SET_W-1:0]. It then issues activate (cmd 2) to the same row exactly T_RP cycles later.
- R3: The first column command comes exactly T_RCD cycles after activate. It is a burst-8 read (cmd 3, dram_bl8=1) at column 0. Tag entry e (32 bits) is carried in beat e/4 at bits [32*(e%4)+31 : 32*(e%4)]. Bit 31 is valid, bit 30 is dirty, and bits [TAG_W-1:0] hold the tag, which is block-address bits [BA_W-1:SET_W].
- R4: A read hits way w when entry w is valid and its tag matches. The controller then issues a burst-4 read at column w+2 and answers with resp_hit=1 and resp_way=w. In resp_rdata, beat b occupies bits [128*b+127 : 128*b].
- R5: An entry whose tag matches but whose valid bit is clear does not produce a hit.
- R6: On a write hit to way w, the controller issues a burst-4 write (cmd 4) at column w+2 with the request block. It then issues a burst-8 write at column 0 with the tag image unchanged except that way w's dirty bit is set. The first data beat of each write comes exactly T_CWL cycles after its command. The response has resp_hit=1 and resp_way=w.
- R7: On a miss where at least one way is invalid, resp_hit=0 and resp_way is the lowest invalid way. No data column read or write is issued on a miss.
- R8: On a miss where all ways are valid, resp_way is the round-robin pointer. The pointer is 0 after reset and advances by one after each such miss, wrapping from 29 to 0. Misses settled by an invalid way leave the pointer unchanged.
- R9: req_ready is 0 from the cycle after acceptance until the response. resp_valid is a one-cycle pulse, and req_ready is 1 in the cycle after it.
- R10: Tag entries 30 and 31 belong to no way and never produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_blk_addr | input | BA_W (26) | Block address: set in low SET_W bits, tag above |
| req_wdata | input | 512 | Block to write |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 = hit |
| resp_way | output | 5 | Hit way or victim way |
| resp_rdata | output | 512 | Block read on a read hit |
| dram_cmd | output | 3 | 0 idle, 1 precharge, 2 activate, 3 read, 4 write |
| dram_row | output | SET_W (17) | Row address |
| dram_col | output | 5 | Slot index within the row |
| dram_bl8 | output | 1 | 1 = burst of 8, 0 = burst of 4 |
| dram_wvalid | output | 1 | Write beat present |
| dram_wdata | output | DQ_W (128) | Write beat |
| dram_rvalid | input | 1 | Read beat present |
| dram_rdata | input | DQ_W (128) | Read beat |

## Verification
A wrong tag capture or a bad comparison shows up in the same response as a wrong hit flag or way. It also shows up as a data read at the wrong column, which returns a block that differs from the expected slot pattern. A round-robin pointer that drifts or moves on the wrong misses shows a wrong victim on the next full-set miss. For that reason the bench sweeps all thirty ways and runs past the pointer's wrap. A corrupted dirty update is not visible in the response; it shows in the tag image written back during the write hit, which the DRAM model compares entry by entry.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dcmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ACT, S_TAGRD, S_TAGCAP, S_CMP,
    S_DRD, S_DCAP, S_DWR, S_TWR, S_WBEAT, S_RESP
  } st_e;

  localparam int ENT_W     = 32;
  localparam int VLD_BIT   = 31;
  localparam int DRT_BIT   = 30;
  localparam int BLK_W     = 512;
  localparam int ROW_SLOTS = 32;
  localparam int TAG_SLOTS = 2;
endpackage

// File: rtl/rtc_tag_match.sv
module rtc_tag_match #(
  parameter int WAYS  = 30,
  parameter int TAG_W = 9,
  parameter int WAY_W = 5
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      look,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  inv_any,
  output logic [WAY_W-1:0]      inv_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == look);
  end

  // lowest index wins for both encoders
  always_comb begin
    hit     = |eq;
    inv_any = ~&vld;
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w])   hit_way = WAY_W'(w);
      if (!vld[w]) inv_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rtc_victim.sv
module rtc_victim #(
  parameter int WAYS  = 30,
  parameter int WAY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_ev,
  input  logic             inv_any,
  input  logic [WAY_W-1:0] inv_way,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] rr_q, rr_n;
  logic             rr_en;

  assign rr_en = miss_ev && !inv_any;

  always_comb begin
    rr_n = rr_q;
    if (rr_en) rr_n = (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_n;
  end

  assign victim = inv_any ? inv_way : rr_q;
endmodule

// File: rtl/rowtag_cache_ctrl.sv
module rowtag_cache_ctrl
  import rtc_pkg::*;
#(
  parameter int BA_W  = 26,
  parameter int SET_W = 17,
  parameter int DQ_W  = 128,
  parameter int T_RP  = 2,
  parameter int T_RCD = 3,
  parameter int T_CWL = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [BA_W-1:0]      req_blk_addr,
  input  logic [BLK_W-1:0]     req_wdata,
  output logic                 req_ready,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [4:0]           resp_way,
  output logic [BLK_W-1:0]     resp_rdata,
  output logic [2:0]           dram_cmd,
  output logic [SET_W-1:0]     dram_row,
  output logic [4:0]           dram_col,
  output logic                 dram_bl8,
  output logic                 dram_wvalid,
  output logic [DQ_W-1:0]      dram_wdata,
  input  logic                 dram_rvalid,
  input  logic [DQ_W-1:0]      dram_rdata
);
  localparam int WAYS     = ROW_SLOTS - TAG_SLOTS;
  localparam int TAG_W    = BA_W - SET_W;
  localparam int WAY_W    = $clog2(WAYS);
  localparam int COL_W    = $clog2(ROW_SLOTS);
  localparam int TIMG_W   = TAG_SLOTS * BLK_W;
  localparam int DBEATS   = BLK_W / DQ_W;
  localparam int TBEATS   = TIMG_W / DQ_W;
  localparam int BEAT_W   = $clog2(TBEATS + 1);
  localparam int TMAX     = (T_RP > T_RCD) ? ((T_RP > T_CWL) ? T_RP : T_CWL)
                                           : ((T_RCD > T_CWL) ? T_RCD : T_CWL);
  localparam int CNT_W    = $clog2(TMAX + 1);
  localparam bit DATA_BL8 = (DBEATS == 8);

  st_e               st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              tph_q, tph_n;
  logic              hit_q, hit_n;
  logic [WAY_W-1:0]  way_q, way_n;
  logic              wr_q;
  logic [BA_W-1:0]   ba_q;
  logic [BLK_W-1:0]  wd_q, rd_q;
  logic [TIMG_W-1:0] tags_q;

  logic [WAYS-1:0]       vld;
  logic [WAYS*TAG_W-1:0] tagf;
  logic                  m_hit, m_inv;
  logic [WAY_W-1:0]      m_way, m_invway, victim;
  logic                  miss_ev;
  dcmd_e                 cmd;
  logic [COL_W-1:0]      col, dcol;
  logic                  bl8, wvalid;
  logic                  acc_en, tcap_en, dcap_en, dirty_en;

  for (genvar w = 0; w < WAYS; w++) begin : g_fld
    assign vld[w]                  = tags_q[w*ENT_W + VLD_BIT];
    assign tagf[w*TAG_W +: TAG_W]  = tags_q[w*ENT_W +: TAG_W];
  end

  rtc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .vld(vld), .tags(tagf), .look(ba_q[BA_W-1:SET_W]),
    .hit(m_hit), .hit_way(m_way), .inv_any(m_inv), .inv_way(m_invway)
  );

  rtc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .miss_ev(miss_ev),
    .inv_any(m_inv), .inv_way(m_invway), .victim(victim)
  );

  assign dcol     = COL_W'(way_q) + COL_W'(TAG_SLOTS);
  assign acc_en   = (st_q == S_IDLE) && req_valid;
  assign tcap_en  = (st_q == S_TAGCAP) && dram_rvalid;
  assign dcap_en  = (st_q == S_DCAP) && dram_rvalid;
  assign dirty_en = (st_q == S_CMP) && m_hit && wr_q;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; beat_n = beat_q; tph_n = tph_q;
    hit_n = hit_q; way_n = way_q;
    cmd = CMD_NOP; col = '0; bl8 = 1'b0; wvalid = 1'b0; miss_ev = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) st_n = S_PRE;
      S_PRE: begin
        cmd = CMD_PRE; cnt_n = CNT_W'(T_RP - 1); st_n = S_ACT;
      end
      S_ACT: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin cmd = CMD_ACT; cnt_n = CNT_W'(T_RCD - 1); st_n = S_TAGRD; end
      end
      S_TAGRD: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin cmd = CMD_RD; bl8 = 1'b1; beat_n = '0; st_n = S_TAGCAP; end
      end
      S_TAGCAP: if (dram_rvalid) begin
        beat_n = beat_q + 1'b1;
        if (beat_q == BEAT_W'(TBEATS - 1)) st_n = S_CMP;
      end
      S_CMP: begin
        if (m_hit) begin
          hit_n = 1'b1; way_n = m_way; st_n = wr_q ? S_DWR : S_DRD;
        end else begin
          hit_n = 1'b0; way_n = victim; miss_ev = 1'b1; st_n = S_RESP;
        end
      end
      S_DRD: begin
        cmd = CMD_RD; col = dcol; bl8 = DATA_BL8; beat_n = '0; st_n = S_DCAP;
      end
      S_DCAP: if (dram_rvalid) begin
        beat_n = beat_q + 1'b1;
        if (beat_q == BEAT_W'(DBEATS - 1)) st_n = S_RESP;
      end
      S_DWR: begin
        cmd = CMD_WR; col = dcol; bl8 = DATA_BL8;
        cnt_n = CNT_W'(T_CWL - 1); beat_n = '0; tph_n = 1'b0; st_n = S_WBEAT;
      end
      S_TWR: begin
        cmd = CMD_WR; bl8 = 1'b1;
        cnt_n = CNT_W'(T_CWL - 1); beat_n = '0; tph_n = 1'b1; st_n = S_WBEAT;
      end
      S_WBEAT: begin
        if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
        else begin
          wvalid = 1'b1; beat_n = beat_q + 1'b1;
          if (!tph_q && beat_q == BEAT_W'(DBEATS - 1)) st_n = S_TWR;
          else if (tph_q && beat_q == BEAT_W'(TBEATS - 1)) st_n = S_RESP;
        end
      end
      S_RESP:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; beat_q <= '0; tph_q <= 1'b0;
      hit_q <= 1'b0; way_q <= '0; wr_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; beat_q <= beat_n; tph_q <= tph_n;
      hit_q <= hit_n; way_q <= way_n;
      if (acc_en) wr_q <= req_write;
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    if (acc_en) begin
      ba_q <= req_blk_addr;
      wd_q <= req_wdata;
    end
    if (tcap_en)  tags_q[beat_q*DQ_W +: DQ_W] <= dram_rdata;
    if (dirty_en) tags_q[m_way*ENT_W + DRT_BIT] <= 1'b1;
    if (dcap_en)  rd_q[beat_q*DQ_W +: DQ_W] <= dram_rdata;
  end

  assign req_ready   = (st_q == S_IDLE);
  assign resp_valid  = (st_q == S_RESP);
  assign resp_hit    = hit_q;
  assign resp_way    = way_q;
  assign resp_rdata  = rd_q;
  assign dram_cmd    = cmd;
  assign dram_row    = ba_q[SET_W-1:0];
  assign dram_col    = col;
  assign dram_bl8    = bl8;
  assign dram_wvalid = wvalid;
  assign dram_wdata  = tph_q ? tags_q[beat_q*DQ_W +: DQ_W] : wd_q[beat_q*DQ_W +: DQ_W];
endmodule

// File: rtl/rowtag_cache_chk.sv
module rowtag_cache_chk #(
  parameter int T_RP  = 2,
  parameter int T_RCD = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic [4:0] resp_way,
  input logic [2:0] dram_cmd,
  input logic [4:0] dram_col,
  input logic       dram_bl8,
  input logic       dram_wvalid
);
  logic [7:0] since_pre, since_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= '0;
      since_act <= '0;
    end else begin
      if (dram_cmd == 3'd1)        since_pre <= 8'd1;
      else if (since_pre != 8'hff) since_pre <= since_pre + 8'd1;
      if (dram_cmd == 3'd2)        since_act <= 8'd1;
      else if (since_act != 8'hff) since_act <= since_act + 8'd1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_cmd == 3'd0 && !dram_wvalid));
  // R2
  pre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == 3'd2) |-> (since_pre == 8'(T_RP)));
  // R3
  act_to_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cmd == 3'd3 && dram_bl8) |-> (dram_col == 5'd0 && since_act == 8'(T_RCD)));
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (req_ready && !resp_valid));
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  way_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_way < 5'd30));
endmodule

bind rowtag_cache_ctrl rowtag_cache_chk #(.T_RP(T_RP), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_way(resp_way), .dram_cmd(dram_cmd),
  .dram_col(dram_col), .dram_bl8(dram_bl8), .dram_wvalid(dram_wvalid)
);

// File: tb/rowtag_cache_ctrl_tb.sv
`timescale 1ns/1ps
module rowtag_cache_ctrl_tb;
  localparam int T_RP = 2, T_RCD = 3, T_CWL = 2, CL = 3;

  logic clk, rst_n;
  logic req_valid, req_write;
  logic [25:0] req_blk_addr;
  logic [511:0] req_wdata;
  logic req_ready, resp_valid, resp_hit;
  logic [4:0] resp_way;
  logic [511:0] resp_rdata;
  logic [2:0] dram_cmd;
  logic [16:0] dram_row;
  logic [4:0] dram_col;
  logic dram_bl8, dram_wvalid, dram_rvalid;
  logic [127:0] dram_wdata, dram_rdata;

  rowtag_cache_ctrl #(.BA_W(26), .SET_W(17), .DQ_W(128), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CWL(T_CWL)) u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, m_checks = 0, m_fails = 0;
  int exp_row = 0;

  logic [127:0] mem [4][128];
  int cyc, t_pre, t_act, orow, rd_wait, rd_left, ridx, wr_left, widx, wr_t;
  int ndcol, nwr, drd_col, dwr_col;
  bit first_col, wfirst;

  function automatic logic [127:0] pat(int r, int i);
    return {32'hA5A50000 | 32'(r), 32'(i), ~32'(i), 32'(r * 1000 + i)};
  endfunction
  function automatic logic [31:0] ent(bit v, bit d, int t);
    return {v, d, 21'b0, 9'(t)};
  endfunction
  function automatic logic [31:0] init_ent(int r, int e);
    case (r)
      0: return (e < 30) ? ent(1, 0, e + 40) : 32'h0;
      1: return (e < 30) ? ent(1, 0, e + 5) : 32'h0;
      2: return (e == 30) ? ent(1, 0, 77) : (e == 31) ? ent(1, 0, 78) : 32'h0;
      default: return (e == 7) ? ent(0, 0, 200) : (e == 20) ? ent(0, 0, 201) :
                      (e < 30) ? ent(1, 0, e + 100) : 32'h0;
    endcase
  endfunction
  function automatic logic [31:0] get_ent(int r, int e);
    return mem[r][e/4][32*(e%4) +: 32];
  endfunction
  function automatic logic [511:0] blk(int r, int slot);
    logic [511:0] v;
    for (int b = 0; b < 4; b++) v[128*b +: 128] = mem[r][slot*4 + b];
    return v;
  endfunction

  task automatic mchk(input bit ok, input string what, input longint act, input longint exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // DRAM model: sees commands and drives read beats at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; rd_left = 0; wr_left = 0; dram_rvalid = 1'b0; dram_rdata = '0;
      t_pre = 0; t_act = 0; orow = 0; first_col = 1'b0;
      for (int r = 0; r < 4; r++) begin
        for (int i = 8; i < 128; i++) mem[r][i] = pat(r, i);
        for (int e = 0; e < 32; e++) mem[r][e/4][32*(e%4) +: 32] = init_ent(r, e);
      end
    end else begin
      cyc++;
      dram_rvalid = 1'b0;
      if (rd_left > 0) begin
        if (rd_wait > 1) rd_wait--;
        else begin
          dram_rvalid = 1'b1; dram_rdata = mem[orow][ridx]; ridx++; rd_left--;
        end
      end
      if (dram_wvalid) begin
        mchk(wr_left > 0, "R6 write beat without command", 1, 0);
        if (wr_left > 0) begin
          if (wfirst) begin
            mchk(cyc - wr_t == T_CWL, "R6 write data latency", cyc - wr_t, T_CWL);
            wfirst = 1'b0;
          end
          mem[orow][widx] = dram_wdata; widx++; wr_left--;
        end
      end
      case (dram_cmd)
        3'd1: begin
          t_pre = cyc; first_col = 1'b1; ndcol = 0; nwr = 0; drd_col = -1; dwr_col = -1;
          mchk(int'(dram_row) == exp_row, "R2 precharge row", dram_row, exp_row);
        end
        3'd2: begin
          mchk(cyc - t_pre == T_RP, "R2 precharge to activate", cyc - t_pre, T_RP);
          mchk(int'(dram_row) == exp_row, "R2 activate row", dram_row, exp_row);
          orow = int'(dram_row[1:0]); t_act = cyc;
        end
        3'd3, 3'd4: begin
          if (first_col) begin
            mchk(cyc - t_act == T_RCD, "R3 activate to tag read", cyc - t_act, T_RCD);
            mchk(dram_cmd == 3'd3 && dram_col == 0 && dram_bl8, "R3 tag read form",
                 {dram_cmd, dram_col, dram_bl8}, {3'd3, 5'd0, 1'b1});
            first_col = 1'b0;
          end else if (dram_col != 0) begin
            ndcol++;
            if (dram_cmd == 3'd3) drd_col = int'(dram_col); else dwr_col = int'(dram_col);
          end
          if (dram_cmd == 3'd3) begin
            rd_wait = CL; rd_left = dram_bl8 ? 8 : 4; ridx = int'(dram_col) * 4;
          end else begin
            wr_left = dram_bl8 ? 8 : 4; widx = int'(dram_col) * 4; wr_t = cyc;
            wfirst = 1'b1; nwr++;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic req(input bit wr, input int row, input int tag, input logic [511:0] wd,
                     output bit hit, output int way, output logic [511:0] rd);
    int n;
    bit busy_bad;
    exp_row = row;
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_blk_addr = {9'(tag), 17'(row)}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; busy_bad = 1'b0;
    while (!resp_valid && n < 300) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(n < 300 && !busy_bad, "R9 busy until response", busy_bad, 0);
    hit = resp_hit; way = int'(resp_way); rd = resp_rdata;
    @(negedge clk);
    chk(req_ready && !resp_valid, "R9 single pulse then ready", {req_ready, resp_valid}, 2'b10);
  endtask

  task automatic finish_run(input int extra);
    $display("TB_RESULT checks=%0d failures=%0d", checks + m_checks, fails + m_fails + extra);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run(1);
  end

  initial begin
    bit h;
    int w;
    logic [511:0] rd, wd;
    logic [31:0] snap [32];
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_blk_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && dram_cmd == 0 && !dram_wvalid, "R1 reset state",
        {req_ready, resp_valid, dram_cmd, dram_wvalid}, 6'b100000);

    // R4: read hit on every way of set 1
    for (int k = 0; k < 30; k++) begin
      req(1'b0, 1, k + 5, '0, h, w, rd);
      chk(h && w == k, "R4 hit way", w, k);
      chk(rd == blk(1, k + 2), "R4 read data", rd[63:0], blk(1, k + 2) & 64'hffffffffffffffff);
      chk(drd_col == k + 2, "R4 data column", drd_col, k + 2);
    end

    // R8: full-set misses walk the pointer across the wrap
    for (int k = 0; k < 31; k++) begin
      req(1'b0, 0, 300, '0, h, w, rd);
      chk(!h && w == k % 30, "R8 round robin victim", w, k % 30);
      chk(ndcol == 0, "R7 no data access on miss", ndcol, 0);
    end

    // R10: entries 30 and 31 never hit; R7 lowest invalid way
    req(1'b0, 2, 77, '0, h, w, rd);
    chk(!h, "R10 spare entry ignored", h, 0);
    chk(w == 0, "R7 first invalid victim", w, 0);

    // R5: invalid entry with matching tag; R7 victim is lowest invalid
    req(1'b0, 3, 200, '0, h, w, rd);
    chk(!h, "R5 invalid entry no hit", h, 0);
    chk(w == 7, "R7 lowest invalid way", w, 7);

    // R8: invalid-way misses leave pointer where it was
    req(1'b0, 0, 300, '0, h, w, rd);
    chk(!h && w == 1, "R8 pointer held", w, 1);

    req(1'b0, 3, 125, '0, h, w, rd);
    chk(h && w == 25, "R4 hit in partly valid set", w, 25);
    chk(rd == blk(3, 27), "R4 read data set 3", rd[63:0], blk(3, 27) & 64'hffffffffffffffff);

    // R6: write hit on set 1 way 4
    for (int e = 0; e < 32; e++) snap[e] = get_ent(1, e);
    for (int b = 0; b < 16; b++) wd[32*b +: 32] = 32'hC0DE0000 + 32'(b * 7);
    req(1'b1, 1, 9, wd, h, w, rd);
    chk(h && w == 4, "R6 write hit way", w, 4);
    chk(dwr_col == 6 && nwr == 2, "R6 data write column and tag write", {dwr_col, nwr}, {6, 2});
    chk(blk(1, 6) == wd, "R6 block stored", blk(1, 6) & 64'hffffffffffffffff, wd[63:0]);
    chk(get_ent(1, 4) == ent(1, 1, 9), "R6 dirty bit set", get_ent(1, 4), ent(1, 1, 9));
    begin
      int diff = 0;
      for (int e = 0; e < 32; e++) if (e != 4 && get_ent(1, e) != snap[e]) diff++;
      chk(diff == 0, "R6 other tag entries unchanged", diff, 0);
    end
    req(1'b0, 1, 9, '0, h, w, rd);
    chk(h && w == 4 && rd == wd, "R6 read back written block", rd[63:0], wd[63:0]);

    // R7: write miss issues no writes
    req(1'b1, 3, 222, wd, h, w, rd);
    chk(!h && w == 7 && nwr == 0 && ndcol == 0, "R7 write miss", {w, nwr}, {7, 0});

    repeat (4) @(negedge clk);
    finish_run(0);
  end
endmodule